// File: doc/BRIEF.md
# Chip-Row Select Decoder with Interleave

This block sits between a memory requester and a bank of up to four rows of memory chips. It takes a 31-bit physical word address and splits it into a 2-bit row number and a 29-bit word address within the row. It then drives one chip-select line per row. All chips in a row share that one select line and are accessed together to form one full-width word, so the block only chooses the row; data timing and chip internals are handled elsewhere.

A static mapping input picks one of two layouts. In contiguous mapping the two top address bits pick the row, so each row covers one quarter of the address space and rows can be fitted one at a time. In interleaved mapping the two bottom address bits pick the row, so consecutive word addresses rotate through the rows and neighbouring accesses can overlap. A fitted mask names the rows that are present. An access to an absent row raises no select and instead gives a one-cycle error pulse.

A small two-state machine guards the configuration. In `ST_IDLE` (no request in the previous cycle) the mapping and mask inputs are taken live and copied into shadow registers. `ST_IDLE -> ST_ACTIVE` is taken on any cycle with `req_valid` high, and `ST_ACTIVE` stays while `req_valid` stays high. In that state the shadow copies are used and frozen. `ST_ACTIVE -> ST_IDLE` is taken on the first cycle with `req_valid` low. All outputs are registered and appear one clock after the request beat that caused them.

Top module: `chip_row_decoder`

## Requirements
- R1: After reset `row_sel` is 0, `acc_err` is 0 and `row_addr` is 0.
- R2: With `map_interleave` = 0, a beat sampled with `req_valid` high gives, one clock later, row = `req_addr[30:29]` and `row_addr` = `req_addr[28:0]`.
- R3: With `map_interleave` = 1, a beat gives, one clock later, row = `req_addr[1:0]` and `row_addr` = `req_addr[30:2]`.
- R4: `row_sel[i]` is the select of row i, and at most one bit of `row_sel` is ever high.
- R5: One clock after a cycle with `req_valid` low, `row_sel` is 0 and `acc_err` is 0, and `row_addr` keeps its previous value.
- R6: `fitted_mask[i]` = 1 marks row i as present. A beat addressed to a row whose mask bit is 0 gives, one clock later, `row_sel` = 0 and `acc_err` = 1 for exactly that cycle; `row_addr` still shows the within-row address.
- R7: Mapping and mask are taken at the first beat of a request, that is, a beat following a cycle with `req_valid` low. Changes made while `req_valid` stays high have no effect until after `req_valid` has been low for at least one cycle.
- R8: Beats on back-to-back cycles are each decoded; in interleaved mapping the addresses N..N+3 with N a multiple of 4 select rows 0,1,2,3 on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request beat present this cycle |
| req_addr | input | 31 | Physical word address |
| map_interleave | input | 1 | 0 = row from top bits, 1 = row from bottom bits |
| fitted_mask | input | 4 | Bit i high when row i is present |
| row_sel | output | 4 | Registered per-row chip select |
| row_addr | output | 29 | Registered word address within the row |
| acc_err | output | 1 | Registered pulse for an access to an absent row |

## Verification
A wrong state bit or a stale shadow register shows up at the ports one clock after the next beat. The select lands on the row the other mapping or the old mask would choose, or an error pulse appears or vanishes where the mask says otherwise. A decode fault shows in the same one-clock window as two selects at once, or as a select on an absent row. The bench changes mapping and mask in the middle of a burst and right after a gap, and checks each beat's select, error and address in the clock that follows it.

// File: rtl/cdec_pkg.sv
package cdec_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } cdec_state_t;

    typedef enum logic [0:0] {
        MAP_CONTIG     = 1'b0,
        MAP_INTERLEAVE = 1'b1
    } cdec_map_t;

endpackage

// File: rtl/cdec_addr_split.sv
module cdec_addr_split
    import cdec_pkg::*;
#(
    parameter int ADDR_W   = 31,
    parameter int ROW_BITS = 2,
    localparam int LOCAL_W = ADDR_W - ROW_BITS
) (
    input  logic [ADDR_W-1:0]   addr,
    input  cdec_map_t           map_mode,
    output logic [ROW_BITS-1:0] row_idx,
    output logic [LOCAL_W-1:0]  local_addr
);

    logic [ROW_BITS-1:0] hi_row;
    logic [LOCAL_W-1:0]  hi_local;
    logic [ROW_BITS-1:0] lo_row;
    logic [LOCAL_W-1:0]  lo_local;

    // Contiguous layout: row from the top bits
    assign hi_row   = addr[ADDR_W-1 -: ROW_BITS];
    assign hi_local = addr[LOCAL_W-1:0];

    // Interleaved layout: row from the bottom bits
    assign lo_row   = addr[ROW_BITS-1:0];
    assign lo_local = addr[ADDR_W-1:ROW_BITS];

    always_comb begin
        unique case (map_mode)
            MAP_CONTIG: begin
                row_idx    = hi_row;
                local_addr = hi_local;
            end
            MAP_INTERLEAVE: begin
                row_idx    = lo_row;
                local_addr = lo_local;
            end
            default: begin
                row_idx    = hi_row;
                local_addr = hi_local;
            end
        endcase
    end

endmodule

// File: rtl/cdec_cfg_hold.sv
module cdec_cfg_hold
    import cdec_pkg::*;
#(
    parameter int ROWS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            map_in,
    input  logic [ROWS-1:0] mask_in,
    output cdec_map_t       map_eff,
    output logic [ROWS-1:0] mask_eff
);

    cdec_state_t     state_q;
    cdec_state_t     state_d;
    cdec_map_t       map_q;
    logic [ROWS-1:0] mask_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)  state_d = ST_ACTIVE;
            ST_ACTIVE: if (!req_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Shadow copies follow the inputs only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q  <= MAP_CONTIG;
            mask_q <= '0;
        end else if (state_q == ST_IDLE) begin
            map_q  <= cdec_map_t'(map_in);
            mask_q <= mask_in;
        end
    end

    // Effective configuration
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                map_eff  = cdec_map_t'(map_in);
                mask_eff = mask_in;
            end
            ST_ACTIVE: begin
                map_eff  = map_q;
                mask_eff = mask_q;
            end
            default: begin
                map_eff  = cdec_map_t'(map_in);
                mask_eff = mask_in;
            end
        endcase
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && req_valid) |=> ($stable(map_q) && $stable(mask_q))); // R7

    AST_ACTIVE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (state_q == ST_ACTIVE)); // R7

endmodule

// File: rtl/cdec_sel_drive.sv
module cdec_sel_drive #(
    parameter int ROWS     = 4,
    parameter int ROW_BITS = 2,
    parameter int LOCAL_W  = 29
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ROW_BITS-1:0] row_idx,
    input  logic [LOCAL_W-1:0]  local_addr,
    input  logic [ROWS-1:0]     mask,
    output logic [ROWS-1:0]     row_sel,
    output logic [LOCAL_W-1:0]  row_addr,
    output logic                acc_err
);

    logic [ROWS-1:0]    dec;
    logic [ROWS-1:0]    sel_d;
    logic               err_d;
    logic [ROWS-1:0]    sel_q;
    logic [LOCAL_W-1:0] addr_q;
    logic               err_q;

    for (genvar gi = 0; gi < ROWS; gi++) begin : g_row
        assign dec[gi]   = req_valid && (row_idx == ROW_BITS'(gi));
        assign sel_d[gi] = dec[gi] && mask[gi];
    end

    assign err_d = req_valid && ((dec & mask) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            addr_q <= '0;
            err_q  <= 1'b0;
        end else begin
            sel_q <= sel_d;
            err_q <= err_d;
            if (req_valid) begin
                addr_q <= local_addr;
            end
        end
    end

    assign row_sel  = sel_q;
    assign row_addr = addr_q;
    assign acc_err  = err_q;

    AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_q)); // R4

    AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (sel_q == '0 && !err_q && $stable(addr_q))); // R5

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (sel_q == '0)); // R6

    AST_SEL_FITTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((sel_q & ~$past(mask)) == '0)); // R6

    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ($countones(sel_q) + (err_q ? 1 : 0) == 1)); // R4

endmodule

// File: rtl/chip_row_decoder.sv
module chip_row_decoder
    import cdec_pkg::*;
#(
    parameter int ADDR_W   = 31,
    parameter int ROW_BITS = 2,
    localparam int ROWS    = 1 << ROW_BITS,
    localparam int LOCAL_W = ADDR_W - ROW_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               map_interleave,
    input  logic [ROWS-1:0]    fitted_mask,
    output logic [ROWS-1:0]    row_sel,
    output logic [LOCAL_W-1:0] row_addr,
    output logic               acc_err
);

    cdec_map_t           map_eff;
    logic [ROWS-1:0]     mask_eff;
    logic [ROW_BITS-1:0] row_idx;
    logic [LOCAL_W-1:0]  local_addr;

    cdec_cfg_hold #(
        .ROWS (ROWS)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .map_in    (map_interleave),
        .mask_in   (fitted_mask),
        .map_eff   (map_eff),
        .mask_eff  (mask_eff)
    );

    cdec_addr_split #(
        .ADDR_W   (ADDR_W),
        .ROW_BITS (ROW_BITS)
    ) u_split (
        .addr       (req_addr),
        .map_mode   (map_eff),
        .row_idx    (row_idx),
        .local_addr (local_addr)
    );

    cdec_sel_drive #(
        .ROWS     (ROWS),
        .ROW_BITS (ROW_BITS),
        .LOCAL_W  (LOCAL_W)
    ) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .row_idx    (row_idx),
        .local_addr (local_addr),
        .mask       (mask_eff),
        .row_sel    (row_sel),
        .row_addr   (row_addr),
        .acc_err    (acc_err)
    );

endmodule

// File: tb/chip_row_decoder_test.sv
module chip_row_decoder_test;

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic [30:0] req_addr;
    logic        map_interleave;
    logic [3:0]  fitted_mask;
    logic [3:0]  row_sel;
    logic [28:0] row_addr;
    logic        acc_err;

    int total;
    int bad;

    chip_row_decoder uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .map_interleave (map_interleave),
        .fitted_mask    (fitted_mask),
        .row_sel        (row_sel),
        .row_addr       (row_addr),
        .acc_err        (acc_err)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Expected row and local address from the mapping rules
    function automatic logic [1:0] ex_row(input logic [30:0] a, input logic il);
        return il ? a[1:0] : a[30:29];
    endfunction

    function automatic logic [28:0] ex_loc(input logic [30:0] a, input logic il);
        return il ? a[30:2] : a[28:0];
    endfunction

    // Drive one beat at the falling edge, check at the next falling edge
    task automatic beat_check(input string tag, input logic [30:0] a,
                              input logic il_exp, input logic [3:0] mask_exp);
        logic [1:0] r;
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        r = ex_row(a, il_exp);
        if (mask_exp[r]) begin
            chk({tag, " sel"}, 64'(row_sel), 64'(4'b0001 << r));
            chk({tag, " err"}, 64'(acc_err), 64'd0);
        end else begin
            chk({tag, " sel"}, 64'(row_sel), 64'd0);
            chk({tag, " err"}, 64'(acc_err), 64'd1);
        end
        chk({tag, " addr"}, 64'(row_addr), 64'(ex_loc(a, il_exp)));
    endtask

    task automatic gap;
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 sel", 64'(row_sel), 64'd0);
        chk("R1 err", 64'(acc_err), 64'd0);
        chk("R1 addr", 64'(row_addr), 64'd0);
    endtask

    task automatic t_contig;
        map_interleave = 1'b0;
        fitted_mask    = 4'hF;
        beat_check("R2 row0", 31'h0000_1234, 1'b0, 4'hF); gap();
        beat_check("R2 row1", 31'h2ABC_DEF1, 1'b0, 4'hF); gap();
        beat_check("R2 row2", 31'h4000_0003, 1'b0, 4'hF); gap();
        beat_check("R2 row3 R4", 31'h7FFF_FFFF, 1'b0, 4'hF); gap();
    endtask

    task automatic t_interleave;
        map_interleave = 1'b1;
        fitted_mask    = 4'hF;
        beat_check("R3 row1", 31'h1234_5671, 1'b1, 4'hF); gap();
        beat_check("R3 row2", 31'h7FFF_FFFE, 1'b1, 4'hF); gap();
        beat_check("R3 row3 R4", 31'h0000_0003, 1'b1, 4'hF); gap();
    endtask

    task automatic t_idle;
        logic [28:0] held;
        map_interleave = 1'b0;
        fitted_mask    = 4'hF;
        beat_check("R5 pre", 31'h1555_5555, 1'b0, 4'hF);
        held = row_addr;
        req_addr  = 31'h7000_0000;
        req_valid = 1'b0;
        @(negedge clk);
        chk("R5 sel", 64'(row_sel), 64'd0);
        chk("R5 err", 64'(acc_err), 64'd0);
        chk("R5 addr hold", 64'(row_addr), 64'(held));
    endtask

    task automatic t_unfitted;
        map_interleave = 1'b0;
        fitted_mask    = 4'b0101;
        beat_check("R6 row1 absent", 31'h2000_0010, 1'b0, 4'b0101);
        beat_check("R6 row2 fitted", 31'h4000_0020, 1'b0, 4'b0101);
        chk("R6 pulse one cycle", 64'(acc_err), 64'd0);
        gap();
        chk("R6 err after gap", 64'(acc_err), 64'd0);
        fitted_mask = 4'b0000;
        beat_check("R6 none fitted", 31'h0000_0001, 1'b0, 4'b0000); gap();
    endtask

    task automatic t_cfg_hold;
        map_interleave = 1'b0;
        fitted_mask    = 4'hF;
        req_valid      = 1'b1;
        req_addr       = 31'h2000_0001;
        @(negedge clk);
        // change configuration mid-request: must be ignored
        map_interleave = 1'b1;
        fitted_mask    = 4'b0001;
        beat_check("R7 frozen map", 31'h6000_0002, 1'b0, 4'hF);
        beat_check("R7 frozen mask", 31'h4000_0003, 1'b0, 4'hF);
        gap();
        beat_check("R7 new cfg", 31'h0000_0006, 1'b1, 4'b0001);
        beat_check("R7 new mask", 31'h0000_0004, 1'b1, 4'b0001);
        gap();
    endtask

    task automatic t_burst;
        map_interleave = 1'b1;
        fitted_mask    = 4'hF;
        for (int k = 0; k < 4; k++) begin
            beat_check($sformatf("R8 beat%0d", k), 31'h0000_0100 + 31'(k), 1'b1, 4'hF);
            chk($sformatf("R8 rot%0d", k), 64'(row_sel), 64'(4'b0001 << k));
        end
        gap();
    endtask

    initial begin
        total = 0;
        bad   = 0;
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_addr  = '0;
        map_interleave = 1'b0;
        fitted_mask    = 4'hF;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_contig();
        t_interleave();
        t_idle();
        t_unfitted();
        t_cfg_hold();
        t_burst();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule